// File: doc/BRIEF.md
# I/O Offload Pipeline Stage

This stage sits between two groups of processing stages and takes slow device accesses out of their path. Each arriving frame carries a set of data registers, an instruction pointer and a flag that marks it as needing no I/O. For an I/O frame, the stage picks two registers chosen by configuration and sends their values to a device as a request. It then holds the frame in an in-order queue. The device answers in the order it was asked. Each answer is written into the oldest waiting frame, either into a configured register or into the instruction pointer, and the frame then moves downstream.

Writing the answer into the instruction pointer turns the device into a multi-way branch: the returned value becomes the next program location. Frames flagged as bypass enter the same queue with no request, so the order of frames is never changed. Upstream stages see only the usual ready backpressure, whatever latency the device has.

Top module: `io_offload_stage`

## Requirements
- R1: While reset is held and just after it is released, out_valid and req_valid are 0 and in_ready is 1 (given req_ready is 1). Reset empties the queue, drops stored responses, and returns the configuration to operand A = register 0, operand B = register 1, destination = register 2.
- R2: An I/O frame (in_bypass = 0) presented while the queue has room raises req_valid, with req_a equal to data register sel_a and req_b equal to data register sel_b. Data register k sits at in_regs[16k+15:16k]. The frame is accepted only in a cycle where req_ready is 1.
- R3: When the destination code is below 8, the frame leaves with that data register replaced by the response. All other registers and the instruction pointer are unchanged.
- R4: Any destination code of 8 or more places the response in out_ip and leaves every data register unchanged.
- R5: A bypass frame raises no request and leaves with its content unchanged. It does not leave before an I/O frame that was accepted ahead of it.
- R6: Frames leave in their order of acceptance. The k-th response is merged into the k-th I/O frame, and an I/O frame is not offered downstream before its response has arrived.
- R7: At most DEPTH frames are held. When the queue is full, in_ready and req_valid are 0.
- R8: While out_valid is 1 and out_ready is 0, the output frame stays the same. A frame is removed only on a cycle where out_valid and out_ready are both 1.
- R9: Configuration writes have no effect while any I/O frame is held in the stage.
- R10: A configuration write with cfg_addr 0 sets the operand A register index, 1 sets operand B, and 2 sets the destination code. Operand indices use the low 3 bits of cfg_wdata, and the destination uses all 4 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration field select |
| cfg_wdata | input | 4 | Configuration value |
| in_valid | input | 1 | Upstream frame valid |
| in_ready | output | 1 | Stage can take the frame |
| in_bypass | input | 1 | Frame needs no I/O |
| in_ip | input | 16 | Incoming instruction pointer |
| in_regs | input | 128 | Incoming data registers, 8 x 16 bits |
| req_valid | output | 1 | Device request valid |
| req_ready | input | 1 | Device can take a request |
| req_a | output | 16 | First request operand |
| req_b | output | 16 | Second request operand |
| rsp_valid | input | 1 | Device response strobe |
| rsp_data | input | 16 | Device response value |
| out_valid | output | 1 | Outgoing frame valid |
| out_ready | input | 1 | Downstream takes the frame |
| out_ip | output | 16 | Outgoing instruction pointer |
| out_regs | output | 128 | Outgoing data registers |

## Verification
A table of single frames sweeps the operand selectors and the destination codes. It includes every register, the branch code 8 and an out-of-range code, so a wrong register or a wrong merge target shows up in a known lane. Mixed runs of I/O and bypass frames show whether a bypass frame can overtake a waiting one and whether responses reach the oldest frame. A run that fills the queue, with all responses sent before any drain, checks capacity, output holding under backpressure, and response matching when several answers are already stored. Late configuration writes, device refusal and a reset in the middle of a run complete the set.

// File: rtl/io_offload_stage.sv
module io_offload_stage #(
  parameter int NREG  = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 4,
  localparam int IW   = $clog2(NREG + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_addr,
  input  logic [IW-1:0]      cfg_wdata,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_bypass,
  input  logic [DW-1:0]      in_ip,
  input  logic [NREG*DW-1:0] in_regs,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [DW-1:0]      req_a,
  output logic [DW-1:0]      req_b,
  input  logic               rsp_valid,
  input  logic [DW-1:0]      rsp_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [DW-1:0]      out_ip,
  output logic [NREG*DW-1:0] out_regs
);
  localparam int LW = $clog2(NREG);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int RB = NREG * DW;
  localparam int FW = 1 + DW + RB;

  logic [FW-1:0] fq [DEPTH];
  logic [DW-1:0] rq [DEPTH];
  logic [PW-1:0] fwp, frp, rwp, rrp;
  logic [CW-1:0] fcnt, rcnt, pend;
  logic [LW-1:0] sel_a, sel_b;
  logic [IW-1:0] dst;
  logic [FW-1:0] head;
  logic          full, push, pop, req_fire, io_pop, rsp_push;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (fcnt == CW'(DEPTH));
  assign req_valid = in_valid && !in_bypass && !full;
  assign in_ready  = !full && (in_bypass || req_ready);
  assign push      = in_valid && in_ready;
  assign req_fire  = push && !in_bypass;
  assign req_a     = in_regs[int'(sel_a)*DW +: DW];
  assign req_b     = in_regs[int'(sel_b)*DW +: DW];

  assign head      = fq[frp];
  assign out_valid = (fcnt != '0) && (head[FW-1] || rcnt != '0);
  assign pop       = out_valid && out_ready;
  assign io_pop    = pop && !head[FW-1];
  assign rsp_push  = rsp_valid && (rcnt != CW'(DEPTH));

  always_comb begin
    out_regs = head[RB-1:0];
    out_ip   = head[RB +: DW];
    if (!head[FW-1]) begin
      if (int'(dst) >= NREG) out_ip = rq[rrp];
      else out_regs[int'(dst[LW-1:0])*DW +: DW] = rq[rrp];
    end
  end

  always_ff @(posedge clk) begin
    if (push) fq[fwp] <= {in_bypass, in_ip, in_regs};
    if (rsp_push) rq[rwp] <= rsp_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwp <= '0; frp <= '0; fcnt <= '0;
      rwp <= '0; rrp <= '0; rcnt <= '0;
      pend  <= '0;
      sel_a <= LW'(0);
      sel_b <= LW'(1);
      dst   <= IW'(2);
    end else begin
      if (push) fwp <= nxt(fwp);
      if (pop)  frp <= nxt(frp);
      fcnt <= fcnt + CW'(push) - CW'(pop);
      if (rsp_push) rwp <= nxt(rwp);
      if (io_pop)   rrp <= nxt(rrp);
      rcnt <= rcnt + CW'(rsp_push) - CW'(io_pop);
      pend <= pend + CW'(req_fire) - CW'(io_pop);
      if (cfg_we && pend == '0) begin
        case (cfg_addr)
          2'd0:    sel_a <= cfg_wdata[LW-1:0];
          2'd1:    sel_b <= cfg_wdata[LW-1:0];
          2'd2:    dst   <= cfg_wdata;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/io_offload_stage_chk.sv
module io_offload_stage_chk #(
  parameter int NREG  = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 4,
  localparam int IW   = $clog2(NREG + 1),
  localparam int LW   = $clog2(NREG),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               in_bypass,
  input logic               req_valid,
  input logic               req_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [DW-1:0]      out_ip,
  input logic [NREG*DW-1:0] out_regs,
  input logic [CW-1:0]      fcnt,
  input logic [CW-1:0]      pend,
  input logic [LW-1:0]      sel_a,
  input logic [LW-1:0]      sel_b,
  input logic [IW-1:0]      dst
);
  a_r7_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt <= CW'(DEPTH));
  a_r7_full_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt == CW'(DEPTH) |-> !in_ready && !req_valid);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_regs) && $stable(out_ip));
  a_r5_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_bypass |-> !req_valid);
  a_r2_refused: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |-> !in_ready);
  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    pend != '0 |=> $stable(sel_a) && $stable(sel_b) && $stable(dst));
endmodule

bind io_offload_stage io_offload_stage_chk #(.NREG(NREG), .DW(DW), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/io_offload_stage_tb.sv
module io_offload_stage_tb;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [1:0] cfg_addr = 0; logic [3:0] cfg_wdata = 0;
  logic in_valid = 0, in_bypass = 0; logic [15:0] in_ip = 0; logic [127:0] in_regs = 0;
  logic req_ready = 1, rsp_valid = 0; logic [15:0] rsp_data = 0;
  logic out_ready = 0;
  logic in_ready, req_valid, out_valid;
  logic [15:0] req_a, req_b, out_ip;
  logic [127:0] out_regs;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  io_offload_stage u_dut (.*);

  // {dst[28:25], bypass[24], tag[23:16], rsp[15:0]}
  localparam logic [28:0] VEC [8] = '{
    {4'd2,  1'b0, 8'h11, 16'hBEEF}, {4'd0,  1'b0, 8'h22, 16'h1234},
    {4'd7,  1'b0, 8'h33, 16'h00FF}, {4'd8,  1'b0, 8'h44, 16'h0040},
    {4'd5,  1'b1, 8'h55, 16'h0000}, {4'd15, 1'b0, 8'h66, 16'h0100},
    {4'd3,  1'b0, 8'h77, 16'hA5A5}, {4'd1,  1'b1, 8'h88, 16'h0000}};

  function automatic logic [127:0] mkr(input logic [7:0] tag);
    logic [127:0] r;
    for (int i = 0; i < 8; i++) r[i*16 +: 16] = {tag, 8'(i)};
    return r;
  endfunction

  task automatic chk(input string r, input logic [127:0] a, input logic [127:0] e);
    nchk++;
    if (a !== e) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", r, a, e);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  task automatic cfgw(input logic [1:0] a, input logic [3:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic drive(input logic byp, input logic [7:0] tag);
    in_valid = 1; in_bypass = byp; in_regs = mkr(tag); in_ip = {8'hC0, tag};
  endtask

  task automatic respond(input logic [15:0] v);
    rsp_valid = 1; rsp_data = v; @(negedge clk); rsp_valid = 0; #1;
  endtask

  task automatic take(input string r, input logic [127:0] er, input logic [15:0] eip);
    chk({r, " out_valid"}, out_valid, 1'b1);
    chk({r, " regs"}, out_regs, er);
    chk({r, " ip"}, out_ip, eip);
    out_ready = 1; @(negedge clk); out_ready = 0; #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++; $display("FAIL watchdog: actual=hung expected=done");
    finish_up();
  end

  initial begin
    logic [127:0] er, held_r; logic [15:0] eip, held_ip;
    repeat (2) @(negedge clk);
    #1;
    chk("R1 reset out_valid", out_valid, 0);
    rst_n = 1; #1;
    chk("R1 in_ready", in_ready, 1);
    chk("R1 req_valid", req_valid, 0);
    chk("R1 out_valid", out_valid, 0);

    // table walk, one frame at a time (R2 R3 R4 R5 R10)
    for (int i = 0; i < 8; i++) begin
      logic [3:0] d; logic b; logic [7:0] t; logic [15:0] rv;
      {d, b, t, rv} = VEC[i];
      @(negedge clk);
      cfgw(2'd0, 4'(i)); cfgw(2'd1, 4'(7 - i)); cfgw(2'd2, d);
      drive(b, t); #1;
      if (!b) begin
        chk("R2 req_valid", req_valid, 1);
        chk("R10 req_a", req_a, {t, 8'(i)});
        chk("R10 req_b", req_b, {t, 8'(7 - i)});
      end else chk("R5 no request", req_valid, 0);
      @(negedge clk); in_valid = 0; #1;
      er = mkr(t); eip = {8'hC0, t};
      if (!b) begin
        chk("R6 waits for response", out_valid, 0);
        respond(rv);
        if (d >= 8) eip = rv; else er[d*16 +: 16] = rv;
        take(d >= 8 ? "R4 branch" : "R3 merge", er, eip);
      end else take("R5 bypass", er, eip);
      chk("R8 popped once", out_valid, 0);
    end

    // ordering with a bypass frame between I/O frames (R5 R6 R9)
    cfgw(2'd2, 4'd3);
    drive(0, 8'hA1); @(negedge clk);
    drive(1, 8'hB2); @(negedge clk);
    drive(0, 8'hC3); @(negedge clk);
    in_valid = 0; #1;
    chk("R5 bypass does not overtake", out_valid, 0);
    cfgw(2'd2, 4'd6);
    respond(16'hAAAA);
    er = mkr(8'hA1); er[3*16 +: 16] = 16'hAAAA;
    take("R9 R6 first frame", er, 16'hC0A1);
    take("R5 middle bypass", mkr(8'hB2), 16'hC0B2);
    chk("R6 third waits", out_valid, 0);
    respond(16'hCCCC);
    er = mkr(8'hC3); er[3*16 +: 16] = 16'hCCCC;
    take("R9 R6 third frame", er, 16'hC0C3);

    // fill, all responses stored, then backpressure and drain (R7 R8 R6)
    for (int k = 0; k < 4; k++) begin drive(0, 8'hD0 + 8'(k)); @(negedge clk); end
    drive(0, 8'hDF); #1;
    chk("R7 full in_ready", in_ready, 0);
    chk("R7 full req_valid", req_valid, 0);
    in_valid = 0;
    for (int k = 0; k < 4; k++) begin
      rsp_valid = 1; rsp_data = 16'h1000 + 16'(k); @(negedge clk);
    end
    rsp_valid = 0; #1;
    held_r = out_regs; held_ip = out_ip;
    repeat (2) @(negedge clk);
    #1;
    chk("R8 held valid", out_valid, 1);
    chk("R8 held regs", out_regs, held_r);
    chk("R8 held ip", out_ip, held_ip);
    for (int k = 0; k < 4; k++) begin
      er = mkr(8'hD0 + 8'(k)); er[3*16 +: 16] = 16'h1000 + 16'(k);
      take("R6 drain order", er, {8'hC0, 8'hD0 + 8'(k)});
    end

    // device refusal (R2)
    req_ready = 0; drive(0, 8'hE5); #1;
    chk("R2 refused req_valid", req_valid, 1);
    chk("R2 refused in_ready", in_ready, 0);
    drive(1, 8'hE6); #1;
    chk("R2 bypass unaffected", in_ready, 1);
    @(negedge clk); in_valid = 0; req_ready = 1; #1;
    take("R5 bypass while refused", mkr(8'hE6), 16'hC0E6);

    // reset mid-run restores defaults (R1 R10)
    drive(0, 8'hF1); @(negedge clk); in_valid = 0;
    rst_n = 0; #1;
    chk("R1 reset clears out", out_valid, 0);
    @(negedge clk); rst_n = 1; #1;
    chk("R1 reset in_ready", in_ready, 1);
    drive(0, 8'hF2); #1;
    chk("R1 default sel_a", req_a, 16'hF200);
    chk("R1 default sel_b", req_b, 16'hF201);
    @(negedge clk); in_valid = 0; #1;
    respond(16'h7777);
    er = mkr(8'hF2); er[2*16 +: 16] = 16'h7777;
    take("R1 default dst", er, 16'hC0F2);
    finish_up();
  end
endmodule